// File: doc/BRIEF.md
# Serial Frame Transmitter with Empty and Complete Flags

This block is the sending side of an asynchronous serial link. Software writes one byte at a time into a single-entry holding register. At each bit-rate tick the block may move that byte into a shift register, which then sends it on a single line as one start bit, eight data bits and one stop bit. A clock-enable input, `tick`, stands in for the baud generator, and each line bit lasts exactly one tick period.

Two sticky flags report progress:

- `empty_flag` shows that the holding register can take another byte.
- `done_flag` shows that the line has gone quiet, with nothing left waiting.

Each flag has its own interrupt enable, and both feed one interrupt output. The block also sends two special frames:

- When `tx_enable` rises, it queues one frame time of idle (all ones).
- While `brk_req` is held, it repeats frames of all zeros.

A transmitter that is switched off partway through a frame still drives the line until that frame's stop bit has ended. It releases the line only after that.

Top module: `sertx_top`

## Requirements
- R1: After synchronous reset, `txd` is 1, `pin_oe` is 0, `empty_flag` and `done_flag` are both 1, and `irq` is 0 while both interrupt enables are 0.
- R2: A write (`wr_en` high with `tx_enable` high) stores the byte, but the line does not start that frame until the next cycle in which `tick` is 1. `txd` changes only on clock edges where `tick` is 1.
- R3: `empty_flag` rises on the tick edge that moves the byte into the shift register. `irq` is 1 whenever `empty_flag` and `empty_ie` are both 1.
- R4: A data frame on `txd` is a 0 start bit, then data bit 0 up to bit 7, then a 1 stop bit, each held for one tick period. A byte written before the current stop bit ends follows that stop bit with no idle gap.
- R5: `done_flag` sets at the tick that ends a frame, but only if no byte, idle frame or break is waiting. If something is waiting, it stays 0. `irq` is 1 whenever `done_flag` and `done_ie` are both 1.
- R6: A rising edge of `tx_enable` clears `done_flag` and queues one frame time (ten ticks) of ones. `done_flag` sets again when that idle frame ends.
- R7: While `brk_req` is 1 and `tx_enable` is 1, the block sends frames of ten 0 bits. Once the request is dropped, the line returns to 1 after the current break frame.
- R8: If `tx_enable` drops during a frame, the frame completes and `pin_oe` stays 1 until its stop bit has ended. After that, `pin_oe` is 0, `done_flag` is 1 and `txd` is 1.
- R9: A write while `tx_enable` is 0 is ignored: both flags keep their values and `txd` stays 1.
- R10: An accepted write clears `empty_flag` and `done_flag` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-rate clock enable, one cycle per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| tx_enable | input | 1 | Transmitter enable |
| brk_req | input | 1 | Send break frames while high |
| empty_ie | input | 1 | Interrupt enable for `empty_flag` |
| done_ie | input | 1 | Interrupt enable for `done_flag` |
| txd | output | 1 | Serial line output |
| pin_oe | output | 1 | High while the block drives the line |
| empty_flag | output | 1 | Holding register can take a byte |
| done_flag | output | 1 | Line idle with nothing queued |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach are the chained frame and the mid-frame shutdown. In a chained frame, a second byte arrives during the stop bit, so `done_flag` must stay low across the frame boundary. In a mid-frame shutdown, the line must stay driven with the enable already gone. The stimulus follows the bit-rate tick edge by edge. It samples every line bit just after its tick. Random bytes are either written during the stop bit or after a random idle gap. Directed sequences drop the enable four bits into a frame and hold the break request across one frame slot.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_IDLE = 2'd1,
    SRC_BRK  = 2'd2
  } src_e;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      empty_flag <= 1'b1;
    end else if (wr_ok) begin
      hold_valid <= 1'b1;
      hold_data  <= wr_data;
      empty_flag <= 1'b0;
    end else if (take) begin
      hold_valid <= 1'b0;
      empty_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/sertx_arb.sv
module sertx_arb
  import sertx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tx_enable,
  input  logic brk_req,
  input  logic hold_valid,
  input  logic slot,
  output logic load,
  output src_e src,
  output logic en_rise
);
  logic en_d;
  logic idle_pend;

  assign en_rise = tx_enable & ~en_d;

  always_comb begin
    if (idle_pend)    src = SRC_IDLE;
    else if (brk_req) src = SRC_BRK;
    else              src = SRC_DATA;
  end

  assign load = slot & tx_enable & (idle_pend | brk_req | hold_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d      <= 1'b0;
      idle_pend <= 1'b0;
    end else begin
      en_d <= tx_enable;
      if (en_rise)                      idle_pend <= 1'b1;
      else if (!tx_enable)              idle_pend <= 1'b0;
      else if (load && src == SRC_IDLE) idle_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  src_e              src,
  input  logic [DATA_W-1:0] data,
  output logic              txd,
  output logic              busy,
  output logic              slot,
  output logic              frame_end
);
  localparam int FW = DATA_W + 2;
  localparam int CW = $clog2(FW);

  logic [FW-1:0] shreg;
  logic [FW-1:0] image;
  logic [CW-1:0] idx;
  logic          last;

  assign last      = busy & (idx == CW'(FW - 1));
  assign slot      = tick & (~busy | last);
  assign frame_end = tick & last;
  assign txd       = shreg[0];

  always_comb begin
    case (src)
      SRC_IDLE: image = '1;
      SRC_BRK:  image = '0;
      default:  image = {1'b1, data, 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '1;
      idx   <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= image;
      idx   <= '0;
      busy  <= 1'b1;
    end else if (tick && busy) begin
      shreg <= {1'b1, shreg[FW-1:1]};
      if (last) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              brk_req,
  input  logic              empty_ie,
  input  logic              done_ie,
  output logic              txd,
  output logic              pin_oe,
  output logic              empty_flag,
  output logic              done_flag,
  output logic              irq
);
  logic              wr_ok;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  src_e              src;
  logic              en_rise;
  logic              busy;
  logic              slot;
  logic              frame_end;
  logic              take;

  assign wr_ok = wr_en & tx_enable;
  assign take  = load & (src == SRC_DATA);

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_data(wr_data), .take(take),
    .hold_valid(hold_valid), .hold_data(hold_data), .empty_flag(empty_flag)
  );

  sertx_arb u_arb (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .brk_req(brk_req),
    .hold_valid(hold_valid), .slot(slot), .load(load), .src(src),
    .en_rise(en_rise)
  );

  sertx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .src(src),
    .data(hold_data), .txd(txd), .busy(busy), .slot(slot),
    .frame_end(frame_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_flag <= 1'b1;
    end else begin
      if (frame_end && !load)  done_flag <= 1'b1;
      if (!busy && !tx_enable) done_flag <= 1'b1;
      if (wr_ok || load || en_rise) done_flag <= 1'b0;
    end
  end

  assign pin_oe = busy | tx_enable;
  assign irq    = (empty_flag & empty_ie) | (done_flag & done_ie);
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic wr_en,
  input logic tx_enable,
  input logic txd,
  input logic pin_oe,
  input logic empty_flag,
  input logic done_flag,
  input logic busy,
  input logic load
);
  p_load_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    load |-> tick);

  p_txd_moves_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(txd));

  p_empty_rise_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_flag) |-> $past(tick));

  p_done_means_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done_flag |-> !busy);

  p_released_high_r8: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> txd);

  p_write_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_enable) |=> (!empty_flag && !done_flag));
endmodule

bind sertx_top sertx_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .tx_enable(tx_enable),
  .txd(txd), .pin_oe(pin_oe), .empty_flag(empty_flag), .done_flag(done_flag),
  .busy(busy), .load(load)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic tx_enable = 1'b0;
  logic brk_req = 1'b0;
  logic empty_ie = 1'b0;
  logic done_ie = 1'b0;
  logic txd, pin_oe, empty_flag, done_flag, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int tcnt = 0;

  always #5 clk = ~clk;

  sertx_top #(.DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .brk_req(brk_req), .empty_ie(empty_ie),
    .done_ie(done_ie), .txd(txd), .pin_oe(pin_oe), .empty_flag(empty_flag),
    .done_flag(done_flag), .irq(irq)
  );

  always @(negedge clk) begin
    if (rst) begin
      tcnt <= 0;
      tick <= 1'b0;
    end else begin
      tcnt <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
      tick <= (tcnt == DIV - 1);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] frame_of(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  task automatic wait_tick();
    do @(posedge clk); while (tick !== 1'b1);
    #2;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic recv(input bit first_done, output logic [9:0] got);
    if (!first_done) wait_tick();
    got[0] = txd;
    check("R3 empty after move", {31'd0, empty_flag}, 32'd1);
    for (int i = 1; i < 10; i++) begin
      wait_tick();
      got[i] = txd;
    end
  endtask

  initial begin
    logic [9:0] got;
    logic [7:0] d;
    logic [7:0] nd;
    bit pre;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    check("R1 txd", {31'd0, txd}, 32'd1);
    check("R1 pin_oe", {31'd0, pin_oe}, 32'd0);
    check("R1 empty", {31'd0, empty_flag}, 32'd1);
    check("R1 done", {31'd0, done_flag}, 32'd1);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rst = 1'b0;

    // R9: write while disabled
    write_byte(8'h5A);
    check("R9 empty", {31'd0, empty_flag}, 32'd1);
    check("R9 done", {31'd0, done_flag}, 32'd1);
    got = '0;
    for (int i = 0; i < 10; i++) begin
      wait_tick();
      got[i] = txd;
    end
    check("R9 line idle", {22'd0, got}, 32'h3FF);
    check("R9 pin released", {31'd0, pin_oe}, 32'd0);

    // R6: preamble on enable rise
    @(negedge clk);
    tx_enable = 1'b1;
    @(negedge clk);
    check("R6 done cleared", {31'd0, done_flag}, 32'd0);
    for (int i = 0; i < 10; i++) begin
      wait_tick();
      got[i] = txd;
    end
    check("R6 ones", {22'd0, got}, 32'h3FF);
    check("R6 done still low", {31'd0, done_flag}, 32'd0);
    wait_tick();
    check("R6 done after idle frame", {31'd0, done_flag}, 32'd1);

    // R2/R3/R5 irq with directed byte
    @(negedge clk);
    empty_ie = 1'b1;
    #1;
    check("R3 irq empty", {31'd0, irq}, 32'd1);
    write_byte(8'hA5);
    check("R10 empty", {31'd0, empty_flag}, 32'd0);
    check("R10 done", {31'd0, done_flag}, 32'd0);
    check("R3 irq low", {31'd0, irq}, 32'd0);
    check("R2 no start before tick", {31'd0, txd}, 32'd1);
    recv(1'b0, got);
    check("R4 frame A5", {22'd0, got}, {22'd0, frame_of(8'hA5)});
    check("R3 irq after move", {31'd0, irq}, 32'd1);
    @(negedge clk);
    empty_ie = 1'b0;
    done_ie = 1'b1;
    #1;
    check("R5 irq before end", {31'd0, irq}, 32'd0);
    wait_tick();
    check("R5 done at end", {31'd0, done_flag}, 32'd1);
    check("R5 irq done", {31'd0, irq}, 32'd1);
    @(negedge clk);
    done_ie = 1'b0;

    // R4/R5 random bytes, chained or spaced
    pre = 1'b0;
    d = '0;
    for (int k = 0; k < 24; k++) begin
      if (!pre) begin
        d = 8'($urandom);
        write_byte(d);
        check("R10 flags cleared", {30'd0, empty_flag, done_flag}, 32'd0);
      end
      recv(pre, got);
      check("R4 frame", {22'd0, got}, {22'd0, frame_of(d)});
      if (k != 23 && ($urandom % 2) == 1) begin
        nd = 8'($urandom);
        write_byte(nd);
        wait_tick();
        check("R5 done held low when chained", {31'd0, done_flag}, 32'd0);
        check("R4 chained start bit", {31'd0, txd}, 32'd0);
        d = nd;
        pre = 1'b1;
      end else begin
        wait_tick();
        check("R5 done", {31'd0, done_flag}, 32'd1);
        check("R4 idle after stop", {31'd0, txd}, 32'd1);
        repeat ($urandom % 20) @(negedge clk);
        pre = 1'b0;
      end
    end

    // R7: break
    @(negedge clk);
    brk_req = 1'b1;
    wait_tick();
    got[0] = txd;
    check("R7 done low during break", {31'd0, done_flag}, 32'd0);
    @(negedge clk);
    brk_req = 1'b0;
    for (int i = 1; i < 10; i++) begin
      wait_tick();
      got[i] = txd;
    end
    check("R7 zeros", {22'd0, got}, 32'd0);
    wait_tick();
    check("R7 line back high", {31'd0, txd}, 32'd1);
    check("R7 done", {31'd0, done_flag}, 32'd1);

    // R8: disable mid-frame
    write_byte(8'h3C);
    for (int i = 0; i < 4; i++) begin
      wait_tick();
      got[i] = txd;
    end
    @(negedge clk);
    tx_enable = 1'b0;
    @(negedge clk);
    check("R8 still driving", {31'd0, pin_oe}, 32'd1);
    for (int i = 4; i < 10; i++) begin
      wait_tick();
      got[i] = txd;
    end
    check("R8 frame completes", {22'd0, got}, {22'd0, frame_of(8'h3C)});
    check("R8 driving in stop bit", {31'd0, pin_oe}, 32'd1);
    wait_tick();
    check("R8 released", {31'd0, pin_oe}, 32'd0);
    check("R8 done", {31'd0, done_flag}, 32'd1);
    check("R8 txd high", {31'd0, txd}, 32'd1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule